// File: doc/BRIEF.md
# Serial Register Control Port

This block is a synchronous-serial slave through which a host microcontroller programs and reads back a small bank of 8-bit control registers. The host frames transfers with an active-low select (`cs_n`), supplies a serial clock (`sclk`) that has no phase relation to the system clock, drives serial data in on `sdi`, and receives readback on `sdo`. `sdo` is qualified by `sdo_oe` so that an outer pad can float it.

A transfer starts with a command byte. The command byte either carries a complete power command or opens a two-byte instruction. A two-byte instruction is a write, in which the host sends a data byte, or a read, in which the host clocks eight more cycles and the port shifts the register out. The two bytes may share one select pulse, or the host may raise `cs_n` between them.

Every completed instruction becomes an event in the serial-clock domain. The event crosses into the system clock domain through a synchronized toggle. There it updates the register bank and the power-down flag, and it raises a one-cycle write strobe for register writes.

Top module: `ser_reg_port`

## Requirements
- R1: After reset `pwr_dn` is 1, every register slot in `reg_bus` is 0, `wr_stb` is 0 and `sdo_oe` is 0.
- R2: While `cs_n` is low, `sdi` is sampled on each rising `sclk` edge, most significant bit first, and eight samples form a byte. In the command byte, bits [7:4] give the register address, bit 2 = 1 selects read, bit 1 = 1 marks a two-byte instruction, and bit 0 is the power bit (1 = power down).
- R3: A write loads its data byte into slot `addr` of `reg_bus` (bits [8*addr+7 : 8*addr]) only after the eighth data bit has been sampled. It raises `wr_stb` for exactly one clock cycle, with `wr_addr` and `wr_data` valid and stable during that cycle.
- R4: The data byte of a two-byte instruction is accepted whether `cs_n` stays low across both bytes or returns high between them.
- R5: A command byte with bit 1 = 0 is a complete instruction that sets `pwr_dn` to its bit 0 and leaves every register unchanged.
- R6: The power bit of a two-byte instruction also sets `pwr_dn`. For a write this happens with the data, and for a read it happens at the end of the command byte.
- R7: After a read command byte, the addressed register appears on `sdo` most significant bit first. Each bit is presented on a falling `sclk` edge, so it is stable at the following rising edge. The register contents are not changed by the read.
- R8: `sdo_oe` is 0 whenever `cs_n` is high, and it is 1 while `cs_n` is low during the data byte of a read.
- R9: If `cs_n` rises before a byte is complete, the partial byte is discarded, and the next byte is decoded as a command byte even if a data byte was expected.
- R10: A write to an address of `NREG` or above changes no register and raises no `wr_stb`. A read of such an address returns 0.
- R11: Registers accept writes and keep their values in both power states.
- R12: When the final rising `sclk` edge of an instruction falls between two rising `clk` edges, `wr_stb` is high during the cycle after the second following rising `clk` edge. `reg_bus` and `pwr_dn` take their new values at the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host, asynchronous to `clk` |
| sdi | input | 1 | Serial data in, sampled on rising `sclk` |
| sdo | output | 1 | Serial readback data, updated on falling `sclk` |
| sdo_oe | output | 1 | Output enable for `sdo` |
| wr_stb | output | 1 | One-cycle register-write strobe in the `clk` domain |
| wr_addr | output | 4 | Address of the current or last write |
| wr_data | output | 8 | Data of the current or last write |
| pwr_dn | output | 1 | Power-down state, 1 = powered down |
| reg_bus | output | NREG*8 | All register slots, slot i at bits [8i+7:8i] |

## Verification
The assertions assume that the host serial clock is slow next to `clk`, with each `sclk` phase lasting at least three `clk` cycles. They also assume that `cs_n` moves only while `sclk` is low and that successive instructions lie several `clk` cycles apart. Under these conditions the event fields are quasi-static whenever the strobe is seen, and register changes can be tied to a preceding strobe. The stimulus changes `cs_n`, `sclk` and `sdi` only on falling `clk` edges. Each `sclk` phase lasts five `clk` cycles, and `cs_n` stays high for several cycles between transfers, so every crossing lands well inside those bounds.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int CNT_W    = $clog2(BYTE_W);
  localparam int F_ADDR   = 4;   // command byte: address field lsb
  localparam int F_READ   = 2;   // command byte: read select
  localparam int F_TWO    = 1;   // command byte: two-byte instruction
  localparam int F_PWR    = 0;   // command byte: power-down bit

  typedef struct packed {
    logic              is_wr;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
    logic              pwr;
  } srp_evt_t;
endpackage

// File: rtl/srp_rx.sv
module srp_rx
  import srp_pkg::*;
(
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [BYTE_W-1:0] rd_val,
  output logic [ADDR_W-1:0] rd_addr,
  output srp_evt_t          evt,
  output logic              evt_tog,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  // bit assembly, cleared whenever select is released
  logic              clr_n;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-2:0] sh_q, sh_d;

  // instruction state, kept across select pulses
  logic              open_q, open_d;
  logic              exp2_q, exp2_d;
  logic              rdph_q, rdph_d;
  logic              ld_q, ld_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d;
  srp_evt_t          evt_q, evt_d;
  logic              tog_q, tog_d;
  logic              bit_en;

  // readback shifter on the falling edge
  logic              so_q, so_d;
  logic [BYTE_W-2:0] osr_q, osr_d;

  logic [BYTE_W-1:0] full;
  logic              last, start, aborted, second;

  assign clr_n  = rst_n & ~cs_n;
  assign bit_en = ~cs_n;

  assign full    = {sh_q, sdi};
  assign last    = (cnt_q == LAST_BIT);
  assign start   = (cnt_q == '0);
  assign aborted = start & open_q;
  assign second  = exp2_q & ~aborted;

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    sh_d   = full[BYTE_W-2:0];
    open_d = ~last;
    exp2_d = aborted ? 1'b0 : exp2_q;
    rdph_d = aborted ? 1'b0 : rdph_q;
    ld_d   = 1'b0;
    cmd_d  = cmd_q;
    evt_d  = evt_q;
    tog_d  = tog_q;
    if (last) begin
      if (second) begin
        exp2_d = 1'b0;
        rdph_d = 1'b0;
        if (!cmd_q[F_READ]) begin
          evt_d.is_wr = 1'b1;
          evt_d.addr  = cmd_q[F_ADDR +: ADDR_W];
          evt_d.data  = full;
          evt_d.pwr   = cmd_q[F_PWR];
          tog_d       = ~tog_q;
        end
      end else if (!full[F_TWO]) begin
        exp2_d      = 1'b0;
        rdph_d      = 1'b0;
        evt_d.is_wr = 1'b0;
        evt_d.pwr   = full[F_PWR];
        tog_d       = ~tog_q;
      end else begin
        cmd_d  = full;
        exp2_d = 1'b1;
        if (full[F_READ]) begin
          rdph_d      = 1'b1;
          ld_d        = 1'b1;
          evt_d.is_wr = 1'b0;
          evt_d.pwr   = full[F_PWR];
          tog_d       = ~tog_q;
        end
      end
    end
  end

  always_ff @(posedge sclk or negedge clr_n) begin
    if (!clr_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      exp2_q <= 1'b0;
      rdph_q <= 1'b0;
      ld_q   <= 1'b0;
      cmd_q  <= '0;
      evt_q  <= '0;
      tog_q  <= 1'b0;
    end else if (bit_en) begin
      open_q <= open_d;
      exp2_q <= exp2_d;
      rdph_q <= rdph_d;
      ld_q   <= ld_d;
      cmd_q  <= cmd_d;
      evt_q  <= evt_d;
      tog_q  <= tog_d;
    end
  end

  always_comb begin
    so_d  = so_q;
    osr_d = osr_q;
    if (rdph_q) begin
      if (ld_q) begin
        so_d  = rd_val[BYTE_W-1];
        osr_d = rd_val[BYTE_W-2:0];
      end else begin
        so_d  = osr_q[BYTE_W-2];
        osr_d = {osr_q[BYTE_W-3:0], 1'b0};
      end
    end
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      so_q  <= 1'b0;
      osr_q <= '0;
    end else begin
      so_q  <= so_d;
      osr_q <= osr_d;
    end
  end

  assign rd_addr = cmd_q[F_ADDR +: ADDR_W];
  assign evt     = evt_q;
  assign evt_tog = tog_q;
  assign sdo     = so_q;
  assign sdo_oe  = ~cs_n & rdph_q;
endmodule

// File: rtl/srp_sync.sv
module srp_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic pulse
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= tog_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign pulse = s2_q ^ s3_q;
endmodule

// File: rtl/srp_regbank.sv
module srp_regbank
  import srp_pkg::*;
#(
  parameter int NREG = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [BYTE_W-1:0]        wdata,
  input  logic                     pwr_we,
  input  logic                     pwr_in,
  output logic [NREG*BYTE_W-1:0]   reg_bus,
  output logic                     pwr_dn
);
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic              hit;
    logic [BYTE_W-1:0] q;
    assign hit = we && (waddr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (hit) q <= wdata;
    end
    assign reg_bus[g*BYTE_W +: BYTE_W] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_dn <= 1'b1;
    else if (pwr_we) pwr_dn <= pwr_in;
  end
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
  import srp_pkg::*;
#(
  parameter int NREG = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic                   sdi,
  output logic                   sdo,
  output logic                   sdo_oe,
  output logic                   wr_stb,
  output logic [3:0]             wr_addr,
  output logic [7:0]             wr_data,
  output logic                   pwr_dn,
  output logic [NREG*8-1:0]      reg_bus
);
  localparam logic [ADDR_W:0] NREG_LIM = (ADDR_W+1)'(NREG);

  logic [1:0]        rs_q;
  logic              sys_rst_n;
  srp_evt_t          evt;
  logic              evt_tog;
  logic              pulse;
  logic              addr_ok;
  logic [ADDR_W-1:0] rd_addr;
  logic [BYTE_W-1:0] rd_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign sys_rst_n = rs_q[1];

  srp_rx u_rx (
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .sdi     (sdi),
    .rd_val  (rd_val),
    .rd_addr (rd_addr),
    .evt     (evt),
    .evt_tog (evt_tog),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe)
  );

  srp_sync u_sync (
    .clk    (clk),
    .rst_n  (sys_rst_n),
    .tog_in (evt_tog),
    .pulse  (pulse)
  );

  assign addr_ok = ({1'b0, evt.addr} < NREG_LIM);
  assign wr_stb  = pulse & evt.is_wr & addr_ok;

  srp_regbank #(.NREG(NREG)) u_bank (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .we      (wr_stb),
    .waddr   (evt.addr),
    .wdata   (evt.data),
    .pwr_we  (pulse),
    .pwr_in  (evt.pwr),
    .reg_bus (reg_bus),
    .pwr_dn  (pwr_dn)
  );

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_val = reg_bus[i*BYTE_W +: BYTE_W];
    end
  end

  assign wr_addr = evt.addr;
  assign wr_data = evt.data;
endmodule

// File: rtl/ser_reg_port_chk.sv
module ser_reg_port_chk #(
  parameter int NREG = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sdo_oe,
  input logic              wr_stb,
  input logic [3:0]        wr_addr,
  input logic [7:0]        wr_data,
  input logic [NREG*8-1:0] reg_bus
);
  localparam logic [4:0] LIM = 5'(NREG);

  function automatic logic [7:0] slot_of(input logic [NREG*8-1:0] b, input logic [3:0] a);
    slot_of = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (a == 4'(i)) slot_of = b[i*8 +: 8];
    end
  endfunction

  assert_oe_needs_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sdo_oe);

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_strobe_commits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (slot_of(reg_bus, $past(wr_addr)) == $past(wr_data)));

  assert_data_quasi_static_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $stable(wr_data) && $stable(wr_addr));

  assert_strobe_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ({1'b0, wr_addr} < LIM));

  assert_change_after_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_bus) |-> $past(wr_stb));
endmodule

bind ser_reg_port ser_reg_port_chk #(.NREG(NREG)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (cs_n),
  .sdo_oe  (sdo_oe),
  .wr_stb  (wr_stb),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .reg_bus (reg_bus)
);

// File: tb/ser_reg_port_bench.sv
`timescale 1ns/1ps
module ser_reg_port_bench;
  localparam int NREG = 10;
  localparam int HALF = 5;

  logic              clk = 1'b0;
  logic              rst_n, cs_n, sclk, sdi;
  logic              sdo, sdo_oe, wr_stb, pwr_dn;
  logic [3:0]        wr_addr;
  logic [7:0]        wr_data;
  logic [NREG*8-1:0] reg_bus;

  int n_cmp = 0;
  int n_bad = 0;
  bit run_cmp = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] exp_regs [NREG];
  logic       exp_pwr;
  logic       exp_rd;
  bit         pend;
  int         stg;
  logic       p_wr;
  logic [3:0] p_addr;
  logic [7:0] p_data;
  logic       p_pwr;

  always #10 clk = ~clk;

  ser_reg_port #(.NREG(NREG)) u_ser_reg_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwr_dn(pwr_dn), .reg_bus(reg_bus)
  );

  function automatic logic [NREG*8-1:0] exp_bus();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = exp_regs[i];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic chk_bus(input string tag);
    n_cmp++;
    if (reg_bus !== exp_bus()) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, reg_bus, exp_bus());
    end
  endtask

  // model: event reaches the system domain two edges after launch, commits on the third (R12)
  always @(posedge clk) begin
    if (pend) begin
      stg = stg + 1;
      if (stg == 3) begin
        exp_pwr = p_pwr;
        if (p_wr && p_addr < NREG) exp_regs[p_addr] = p_data;
        pend = 0;
        stg = 0;
      end
    end
  end

  // per-cycle comparison, a quarter period after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (run_cmp) begin
        chk("R12 wr_stb timing", 32'(wr_stb), 32'(pend && stg == 2 && p_wr && p_addr < NREG));
        chk_bus("R3 reg_bus per cycle");
        chk("R5 pwr_dn per cycle", 32'(pwr_dn), 32'(exp_pwr));
        chk("R8 sdo_oe per cycle", 32'(sdo_oe), 32'(exp_rd && !cs_n));
      end
    end
  end

  // act: 0 none, 1 launch event, 2 launch and enter read phase, 3 leave read phase
  task automatic drive_bit(input logic b, input int act, input bit rchk, input logic expb);
    sdi = b;
    repeat (HALF) @(negedge clk);
    if (rchk) chk("R7 sdo bit", 32'(sdo), 32'(expb));
    sclk = 1'b1;
    if (act == 1 || act == 2) begin pend = 1; stg = 0; end
    if (act == 2) exp_rd = 1'b1;
    if (act == 3) exp_rd = 1'b0;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input int last_act, input bit rchk, input logic [7:0] expv);
    for (int i = 7; i >= 0; i--) drive_bit(v[i], (i == 0) ? last_act : 0, rchk, expv[i]);
  endtask

  task automatic sel(input logic lvl);
    @(negedge clk);
    cs_n = lvl;
    repeat (3) @(negedge clk);
  endtask

  task automatic idle();
    repeat (8) @(negedge clk);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d, input logic p, input bit split);
    p_wr = 1; p_addr = a; p_data = d; p_pwr = p;
    sel(1'b0);
    send_byte({a, 1'b0, 1'b0, 1'b1, p}, 0, 0, 8'h00);
    if (split) begin sel(1'b1); sel(1'b0); end
    send_byte(d, 1, 0, 8'h00);
    sel(1'b1);
    idle();
  endtask

  task automatic do_read(input logic [3:0] a, input logic p, input bit split, input logic [7:0] expv);
    p_wr = 0; p_addr = a; p_data = 8'h00; p_pwr = p;
    sel(1'b0);
    send_byte({a, 1'b0, 1'b1, 1'b1, p}, 2, 0, 8'h00);
    if (split) begin sel(1'b1); sel(1'b0); end
    send_byte(8'h00, 3, 1, expv);
    sel(1'b1);
    idle();
  endtask

  task automatic do_power(input logic p);
    p_wr = 0; p_addr = 4'h0; p_data = 8'h00; p_pwr = p;
    sel(1'b0);
    send_byte({4'h0, 1'b0, 1'b0, 1'b0, p}, 1, 0, 8'h00);
    sel(1'b1);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
    exp_pwr = 1'b1; exp_rd = 1'b0; pend = 0; stg = 0;
    p_wr = 0; p_addr = 0; p_data = 0; p_pwr = 1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 pwr_dn", 32'(pwr_dn), 32'd1);
    chk("R1 reg_bus zero", 32'(reg_bus == '0), 32'd1);
    chk("R1 wr_stb", 32'(wr_stb), 32'd0);
    chk("R1 sdo_oe", 32'(sdo_oe), 32'd0);
    run_cmp = 1;

    // R3 R11 write while powered down, one select pulse
    do_write(4'd3, 8'hA5, 1'b1, 0);
    chk("R3 slot3", 32'(reg_bus[3*8 +: 8]), 32'hA5);
    chk("R11 still powered down", 32'(pwr_dn), 32'd1);

    // R2 msb first
    do_write(4'd1, 8'h01, 1'b1, 0);
    chk("R2 slot1 msb first", 32'(reg_bus[1*8 +: 8]), 32'h01);

    // R4 R6 split write that also powers up
    do_write(4'd7, 8'h3C, 1'b0, 1);
    chk("R4 slot7 split", 32'(reg_bus[7*8 +: 8]), 32'h3C);
    chk("R6 power up via write", 32'(pwr_dn), 32'd0);

    // R5 single-byte power commands
    do_power(1'b1);
    chk("R5 power down cmd", 32'(pwr_dn), 32'd1);
    chk("R5 regs untouched", 32'(reg_bus[3*8 +: 8]), 32'hA5);
    do_power(1'b0);
    chk("R5 power up cmd", 32'(pwr_dn), 32'd0);
    chk("R11 slot7 retained", 32'(reg_bus[7*8 +: 8]), 32'h3C);

    // R7 contiguous read, R6 read power bit
    do_read(4'd3, 1'b0, 0, 8'hA5);
    chk("R7 read leaves slot3", 32'(reg_bus[3*8 +: 8]), 32'hA5);
    do_read(4'd7, 1'b1, 1, 8'h3C);
    chk("R6 power down via read", 32'(pwr_dn), 32'd1);
    chk("R4 split read leaves slot7", 32'(reg_bus[7*8 +: 8]), 32'h3C);

    // R10 out of range
    do_write(4'd12, 8'hFF, 1'b0, 0);
    chk_bus("R10 no change on out-of-range write");
    chk("R10 power bit still applied", 32'(pwr_dn), 32'd0);
    do_read(4'd13, 1'b0, 0, 8'h00);

    // R9 abort in a command byte
    sel(1'b0);
    for (int i = 0; i < 3; i++) drive_bit(1'b1, 0, 0, 1'b0);
    sel(1'b1);
    idle();
    do_write(4'd0, 8'h81, 1'b0, 0);
    chk("R9 write after aborted command", 32'(reg_bus[0*8 +: 8]), 32'h81);

    // R9 abort in a data byte, next byte decoded as a command
    sel(1'b0);
    send_byte({4'd2, 1'b0, 1'b0, 1'b1, 1'b0}, 0, 0, 8'h00);
    for (int i = 0; i < 4; i++) drive_bit(1'b1, 0, 0, 1'b0);
    sel(1'b1);
    idle();
    do_write(4'd9, 8'h5A, 1'b0, 0);
    chk("R9 aborted data discarded", 32'(reg_bus[2*8 +: 8]), 32'h00);
    chk("R9 new command honoured", 32'(reg_bus[9*8 +: 8]), 32'h5A);
    do_read(4'd9, 1'b0, 0, 8'h5A);

    repeat (10) @(negedge clk);
    run_cmp = 0;
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule